// File: doc/BRIEF.md
# Interrupt Request Acceptance Unit

This unit sits between a set of device interrupt request lines and the next-address logic of a simple single-cycle processor. Each cycle it looks at the registered request lines and decides whether one of them is taken. When a line is taken, the unit does four things in the same cycle. It pulses an acknowledge back to that device so the device can drop its request. It tells the next-address logic to fetch from a fixed handler vector. It saves the address of the next sequential instruction, together with the current mask and priority level. It then raises the global mask so that no further interrupt is taken.

A handler that wants to allow nesting pulses an enable input. This clears the mask, but only lines of strictly higher priority than the one being served may then interrupt it. Line 0 has the highest priority. A return strobe pops the saved context: the next-address logic is redirected to the saved return address, and the mask and level are restored. The saved contexts sit in a small stack, so handlers can nest as deep as the stack allows.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, irq_ack_o, irq_take_o and redirect_o are 0, mask_o is 0, and level_o equals N_LINES. The value N_LINES means that no handler is active.
- R2: Requests are registered before they are evaluated. A request first present at clock edge k can be acknowledged at the earliest in the cycle that follows edge k.
- R3: irq_ack_o is zero or one-hot, and bit i answers irq_req_i bit i. An acknowledge lasts exactly one cycle.
- R4: In the cycle of acceptance, irq_take_o and redirect_o are 1 and redirect_addr_o equals HANDLER_VEC.
- R5: Acceptance sets mask_o from the next cycle on. While mask_o is 1, no line is accepted.
- R6: When several eligible lines request together, the lowest-numbered line is acknowledged.
- R7: An ie_enable_i pulse clears mask_o at the next edge. While a handler at level L runs unmasked, only lines with an index below L are accepted. Acceptance of line i sets level_o to i.
- R8: After a line has been acknowledged, it is not accepted again until its registered request has been low for at least one cycle.
- R9: An eret_i pulse with a non-empty stack asserts redirect_o with redirect_addr_o equal to the pc_seq_i value captured when the matching interrupt was accepted. From the next cycle on, mask_o and level_o hold the values they had before that acceptance.
- R10: An eret_i pulse with an empty stack has no effect: redirect_o stays 0 and the mask and level do not change. No line is accepted in a cycle where eret_i is 1. When eret_i and ie_enable_i arrive together, eret_i wins.
- R11: redirect_addr_o is 0 whenever redirect_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | N_LINES | Device request lines; bit 0 has the highest priority |
| ie_enable_i | input | 1 | Software pulse that clears the mask so higher-priority lines can nest |
| eret_i | input | 1 | Return-from-handler strobe |
| pc_seq_i | input | ADDR_W | Address of the next sequential instruction |
| irq_ack_o | output | N_LINES | One-cycle acknowledge to the accepted line |
| irq_take_o | output | 1 | An interrupt is taken this cycle |
| redirect_o | output | 1 | Next-address override is valid |
| redirect_addr_o | output | ADDR_W | Handler vector or restored return address |
| mask_o | output | 1 | Global interrupt mask |
| level_o | output | $clog2(N_LINES+1) | Index of the line being served; N_LINES when idle |

## Verification
The assertions assume that eret_i is pulsed only while a handler context exists, or else that the unit's idle response to it is harmless. They also assume that the acknowledge-driven level only ever decreases on acceptance. Both hold because the unit itself gates acceptance on the active level and ignores a return on an empty stack. The random stimulus toggles each request line freely and pulses enable and return at modest rates, so that nesting up to full stack depth happens on its own. The stimulus also produces empty-stack returns and requests that are held high. Directed sequences pin the exact priority, re-arm, blocked-by-return and restored-address cases.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;
endpackage

// File: rtl/irq_req_sync.sv
`timescale 1ns/1ps
module irq_req_sync #(
  parameter int N_LINES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] disarm_i,
  output logic [N_LINES-1:0] req_q_o,
  output logic [N_LINES-1:0] armed_o
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        req_q_o[i] <= 1'b0;
        armed_o[i] <= 1'b1;
      end else begin
        req_q_o[i] <= req_i[i];
        // re-arm only after the registered request was seen low
        if (disarm_i[i])     armed_o[i] <= 1'b0;
        else if (!req_q_o[i]) armed_o[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
  parameter int N_LINES = 4,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] elig_i,
  output logic [N_LINES-1:0] grant_o,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [N_LINES:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_LINES; i++) begin : g_chain
    assign grant_o[i]  = elig_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | elig_i[i];
  end

  assign any_o = seen[N_LINES];

  always_comb begin
    idx_o = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (elig_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_ctx_stack.sv
`timescale 1ns/1ps
module irq_ctx_stack
  import irq_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int LVL_W  = 3,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  stk_op_e           op_i,
  input  logic              push_mask_i,
  input  logic [LVL_W-1:0]  push_lvl_i,
  input  logic [ADDR_W-1:0] push_ra_i,
  output logic              top_mask_o,
  output logic [LVL_W-1:0]  top_lvl_o,
  output logic [ADDR_W-1:0] top_ra_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [ADDR_W-1:0] ra_mem   [DEPTH];
  logic [LVL_W-1:0]  lvl_mem  [DEPTH];
  logic              mask_mem [DEPTH];
  logic [SP_W-1:0]   sp_q;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic              do_push, do_pop;

  assign empty_o = (sp_q == '0);
  assign full_o  = (sp_q == SP_W'(DEPTH));
  assign wr_idx  = sp_q[IDX_W-1:0];
  assign rd_idx  = IDX_W'(sp_q - SP_W'(1));
  assign do_push = (op_i == STK_PUSH) && !full_o;
  assign do_pop  = (op_i == STK_POP) && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp_q <= '0;
    else if (do_push) sp_q <= sp_q + SP_W'(1);
    else if (do_pop)  sp_q <= sp_q - SP_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (do_push) begin
      ra_mem[wr_idx]   <= push_ra_i;
      lvl_mem[wr_idx]  <= push_lvl_i;
      mask_mem[wr_idx] <= push_mask_i;
    end
  end

  assign top_ra_o   = ra_mem[rd_idx];
  assign top_lvl_o  = lvl_mem[rd_idx];
  assign top_mask_o = mask_mem[rd_idx];
endmodule

// File: rtl/irq_accept_unit.sv
`timescale 1ns/1ps
module irq_accept_unit
  import irq_pkg::*;
#(
  parameter int                N_LINES     = 4,
  parameter int                ADDR_W      = 32,
  parameter int                STACK_DEPTH = 4,
  parameter logic [ADDR_W-1:0] HANDLER_VEC = 'h80,
  localparam int               LVL_W       = $clog2(N_LINES + 1),
  localparam int               IDX_W       = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_req_i,
  input  logic               ie_enable_i,
  input  logic               eret_i,
  input  logic [ADDR_W-1:0]  pc_seq_i,
  output logic [N_LINES-1:0] irq_ack_o,
  output logic               irq_take_o,
  output logic               redirect_o,
  output logic [ADDR_W-1:0]  redirect_addr_o,
  output logic               mask_o,
  output logic [LVL_W-1:0]   level_o
);
  logic [N_LINES-1:0] req_q, armed, elig, grant;
  logic               any_win, gate, pop;
  logic [IDX_W-1:0]   win_idx;
  logic               mask_q;
  logic [LVL_W-1:0]   lvl_q;
  logic               top_mask, stk_empty, stk_full;
  logic [LVL_W-1:0]   top_lvl;
  logic [ADDR_W-1:0]  top_ra;
  stk_op_e            stk_op;

  irq_req_sync #(.N_LINES(N_LINES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (irq_req_i),
    .disarm_i (grant),
    .req_q_o  (req_q),
    .armed_o  (armed)
  );

  // a return in flight or a full stack blocks acceptance
  assign gate = ~mask_q & ~eret_i & ~stk_full;

  for (genvar i = 0; i < N_LINES; i++) begin : g_elig
    assign elig[i] = req_q[i] & armed[i] & gate & (lvl_q > LVL_W'(i));
  end

  irq_prio_pick #(.N_LINES(N_LINES)) u_pick (
    .elig_i  (elig),
    .grant_o (grant),
    .any_o   (any_win),
    .idx_o   (win_idx)
  );

  assign pop = eret_i & ~stk_empty;

  always_comb begin
    if (any_win)  stk_op = STK_PUSH;
    else if (pop) stk_op = STK_POP;
    else          stk_op = STK_IDLE;
  end

  irq_ctx_stack #(
    .DEPTH  (STACK_DEPTH),
    .ADDR_W (ADDR_W),
    .LVL_W  (LVL_W)
  ) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (stk_op),
    .push_mask_i (mask_q),
    .push_lvl_i  (lvl_q),
    .push_ra_i   (pc_seq_i),
    .top_mask_o  (top_mask),
    .top_lvl_o   (top_lvl),
    .top_ra_o    (top_ra),
    .empty_o     (stk_empty),
    .full_o      (stk_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= 1'b0;
      lvl_q  <= LVL_W'(N_LINES);
    end else if (any_win) begin
      mask_q <= 1'b1;
      lvl_q  <= LVL_W'(win_idx);
    end else if (pop) begin
      mask_q <= top_mask;
      lvl_q  <= top_lvl;
    end else if (ie_enable_i) begin
      mask_q <= 1'b0;
    end
  end

  assign irq_ack_o  = grant;
  assign irq_take_o = any_win;
  assign redirect_o = any_win | pop;

  always_comb begin
    if (any_win)  redirect_addr_o = HANDLER_VEC;
    else if (pop) redirect_addr_o = top_ra;
    else          redirect_addr_o = '0;
  end

  assign mask_o  = mask_q;
  assign level_o = lvl_q;
endmodule

// File: rtl/irq_accept_chk.sv
`timescale 1ns/1ps
module irq_accept_chk #(
  parameter int                N_LINES     = 4,
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] HANDLER_VEC = 'h80,
  localparam int               LVL_W       = $clog2(N_LINES + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_LINES-1:0] irq_req_i,
  input logic [N_LINES-1:0] irq_ack_o,
  input logic               irq_take_o,
  input logic               redirect_o,
  input logic [ADDR_W-1:0]  redirect_addr_o,
  input logic               mask_o,
  input logic [LVL_W-1:0]   level_o
);
  assert_ack_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_ack_o));

  assert_ack_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_o != '0) |=> (irq_ack_o == '0));

  assert_take_vector_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (redirect_o && redirect_addr_o == HANDLER_VEC));

  assert_mask_raise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |=> mask_o);

  assert_masked_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_o |-> (irq_ack_o == '0));

  assert_level_rises_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |=> (level_o < $past(level_o)));

  assert_idle_addr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !redirect_o |-> (redirect_addr_o == '0));

  for (genvar i = 0; i < N_LINES; i++) begin : g_req
    assert_ack_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_ack_o[i] |-> $past(irq_req_i[i]));
  end
endmodule

bind irq_accept_unit irq_accept_chk #(
  .N_LINES     (N_LINES),
  .ADDR_W      (ADDR_W),
  .HANDLER_VEC (HANDLER_VEC)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .irq_req_i       (irq_req_i),
  .irq_ack_o       (irq_ack_o),
  .irq_take_o      (irq_take_o),
  .redirect_o      (redirect_o),
  .redirect_addr_o (redirect_addr_o),
  .mask_o          (mask_o),
  .level_o         (level_o)
);

// File: tb/tb_irq_accept_unit.sv
`timescale 1ns/1ps
module tb_irq_accept_unit;
  localparam int          NL  = 4;
  localparam int          AW  = 32;
  localparam int          SD  = 4;
  localparam logic [31:0] VEC = 32'h0000_0080;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] req = '0;
  logic          en = 1'b0, eret = 1'b0;
  logic [AW-1:0] pc = '0;
  logic [NL-1:0] ack;
  logic          take, redir, mask;
  logic [AW-1:0] raddr;
  logic [2:0]    lvl;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [NL-1:0] m_req, m_arm;
  logic          m_mask;
  int            m_lvl, m_sp;
  logic [AW-1:0] s_ra [SD];
  logic          s_mask [SD];
  int            s_lvl [SD];

  always #2 clk = ~clk;

  irq_accept_unit #(.N_LINES(NL), .ADDR_W(AW), .STACK_DEPTH(SD), .HANDLER_VEC(VEC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .ie_enable_i(en), .eret_i(eret),
    .pc_seq_i(pc), .irq_ack_o(ack), .irq_take_o(take), .redirect_o(redir),
    .redirect_addr_o(raddr), .mask_o(mask), .level_o(lvl)
  );

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic int pick_line(logic t);
    for (int i = 0; i < NL; i++)
      if (m_req[i] && m_arm[i] && !m_mask && i < m_lvl && m_sp < SD && !t) return i;
    return -1;
  endfunction

  task automatic cyc(logic [NL-1:0] r, logic e, logic t, logic [AW-1:0] p, string tag);
    int k;
    logic pop;
    logic [NL-1:0] e_ack;
    logic [AW-1:0] e_addr;
    @(negedge clk);
    req = r; en = e; eret = t; pc = p;
    #1;
    k = pick_line(t);
    pop = t && (m_sp > 0);
    e_ack = (k >= 0) ? NL'(1 << k) : '0;
    e_addr = (k >= 0) ? VEC : (pop ? s_ra[m_sp-1] : '0);
    check(tag, "ack", 64'(ack), 64'(e_ack));
    check(tag, "take", 64'(take), 64'(k >= 0));
    check(tag, "redirect", 64'(redir), 64'((k >= 0) || pop));
    check(tag, "addr", 64'(raddr), 64'(e_addr));
    check(tag, "mask", 64'(mask), 64'(m_mask));
    check(tag, "level", 64'(lvl), 64'(m_lvl));
    // advance model to the coming edge
    for (int i = 0; i < NL; i++) begin
      if (k == i) m_arm[i] = 1'b0;
      else if (!m_req[i]) m_arm[i] = 1'b1;
    end
    if (k >= 0) begin
      s_ra[m_sp] = p; s_mask[m_sp] = m_mask; s_lvl[m_sp] = m_lvl;
      m_sp++; m_mask = 1'b1; m_lvl = k;
    end else if (pop) begin
      m_sp--; m_mask = s_mask[m_sp]; m_lvl = s_lvl[m_sp];
    end else if (e) begin
      m_mask = 1'b0;
    end
    m_req = r;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_req = '0; m_arm = '1; m_mask = 1'b0; m_lvl = NL; m_sp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1", "ack", 64'(ack), 0);
    check("R1", "take", 64'(take), 0);
    check("R1", "redirect", 64'(redir), 0);
    check("R1", "mask", 64'(mask), 0);
    check("R1", "level", 64'(lvl), NL);

    // directed sequence
    cyc(4'b0110, 0, 0, 32'h100, "R2");
    check("R2", "ack before register", 64'(ack), 0);
    cyc(4'b0110, 0, 0, 32'h104, "R6");
    check("R6", "lowest line wins", 64'(ack), 64'(4'b0010));
    check("R4", "handler vector", 64'(raddr), 64'(VEC));
    cyc(4'b0110, 0, 0, 32'h200, "R3");
    check("R5", "masked no ack", 64'(ack), 0);
    cyc(4'b0100, 1, 0, 32'h204, "R7");
    cyc(4'b0100, 0, 0, 32'h208, "R7");
    check("R7", "lower priority blocked", 64'(ack), 0);
    cyc(4'b0101, 0, 0, 32'h300, "R7");
    cyc(4'b0101, 0, 0, 32'h304, "R7");
    check("R7", "higher priority nests", 64'(ack), 64'(4'b0001));
    cyc(4'b0100, 0, 1, 32'h308, "R9");
    check("R9", "return address", 64'(raddr), 64'(32'h304));
    cyc(4'b0110, 0, 0, 32'h30c, "R9");
    check("R9", "mask restored", 64'(mask), 0);
    check("R9", "level restored", 64'(lvl), 1);
    cyc(4'b0110, 0, 1, 32'h310, "R10");
    check("R10", "eret blocks accept", 64'(ack), 0);
    check("R9", "outer return address", 64'(raddr), 64'(32'h104));
    cyc(4'b0110, 0, 0, 32'h400, "R8");
    check("R8", "rearmed line taken", 64'(ack), 64'(4'b0010));
    cyc(4'b0010, 0, 1, 32'h404, "R9");
    cyc(4'b0010, 0, 0, 32'h408, "R8");
    check("R8", "held request not retaken", 64'(ack), 0);
    cyc(4'b0000, 0, 0, 32'h40c, "R8");
    cyc(4'b0010, 0, 0, 32'h410, "R8");
    cyc(4'b0010, 0, 0, 32'h414, "R8");
    check("R8", "taken after low", 64'(ack), 64'(4'b0010));
    cyc(4'b0000, 0, 1, 32'h418, "R9");
    cyc(4'b0000, 1, 1, 32'h41c, "R10");
    check("R10", "empty eret redirect", 64'(redir), 0);
    check("R11", "idle addr zero", 64'(raddr), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [NL-1:0] r;
      r = req;
      for (int i = 0; i < NL; i++)
        if ($urandom_range(0, 3) == 0) r[i] = ~r[i];
      cyc(r, ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0), $urandom, "R6");
    end
    finish_run();
  end
endmodule